// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block keeps an SDRAM's contents alive on behalf of a memory controller. An interval counter, sized from the clock frequency, builds up refresh debt. While debt is outstanding the block raises a request to the controller's command arbiter. Once the arbiter grants it, the block takes the command bus. It closes every bank, waits out the precharge time and then issues one or more AUTO REFRESH commands. It hands the bus back when the last refresh cycle time has elapsed.

Two refresh schedules are selectable at run time. In the spread schedule one refresh falls due per average interval, and up to eight can queue up while the arbiter is busy elsewhere. In the batch schedule the whole set of refreshes falls due once per retention window and is issued back to back.

The same request path also moves the device into its low-power self-refresh state. The block closes the banks, issues the refresh encoding with the clock enable low, and holds the clock enable low for as long as asked, but never for less than the minimum residency. On exit it raises the clock enable, waits out the exit time, and issues one fresh AUTO REFRESH before it frees the bus.

Top module: `sdram_refresh_seq`

## Requirements
- R1: While reset is asserted and right after it, busy and rf_req are low, cke is high and the command pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, a10=0).
- R2: With burst_mode low, a pending refresh is added about every REFI_NS of clock time, and rf_req goes high while any refresh is pending.
- R3: Every granted sequence starts with PRECHARGE ALL (cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1). The first AUTO REFRESH (cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=1) or self-refresh entry follows exactly ceil(T_RP_NS*CLK_MHZ/1000) cycles later.
- R4: Back-to-back AUTO REFRESH commands are spaced by the refresh cycle time in cycles. busy drops exactly that many cycles after the last one.
- R5: Pending spread-mode refreshes saturate at PEND_MAX. After a long wait without a grant, exactly PEND_MAX refreshes are drained in one sequence.
- R6: With burst_mode high, BURST_LEN refreshes fall due once per WINDOW_NS and are issued in one sequence at refresh-cycle spacing.
- R7: When sr_req is high, the sequence ends in self-refresh entry: the refresh encoding with cke low in the same cycle. cke then stays low and busy stays high while sr_req remains high.
- R8: cke stays low for at least the residency time in cycles, and for exactly that long when sr_req drops at entry.
- R9: After self-refresh, cke rises, an AUTO REFRESH follows exactly the exit time in cycles later, and busy drops a refresh cycle time after that.
- R10: grant has no effect while rf_req is low: busy stays low and no command is issued.
- R11: During self-refresh residency after the entry cycle, the device is deselected (cs_n=1).
- R12: rf_req is only high while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_mode | input | 1 | 1 selects the batch schedule, 0 the spread schedule |
| sr_req | input | 1 | High asks for self-refresh and holds it; low asks to leave |
| grant | input | 1 | Arbiter grant of the command bus, sampled while rf_req is high |
| rf_req | output | 1 | Request for the command bus |
| busy | output | 1 | High while the block owns the command bus |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10, high selects all banks for precharge |

## Verification
The bound checker watches the timing rules on every cycle. It checks that no refresh comes before the precharge time, that refreshes never come closer than the refresh cycle time, and that a refresh never comes sooner than the exit time after cke rises. It also checks the clock-enable residency, the deselect during self-refresh, the link between busy and rf_req, and that a grant without a request does nothing. Only the bench scenarios can show how many refreshes a sequence carries. That covers the saturation of queued debt at eight, the batch count and window, the interval spacing, and the exact exit and residency cycle counts when sr_req drops at once.

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq #(
  parameter int     CLK_MHZ   = 133,
  parameter int     T_RP_NS   = 20,
  parameter int     T_RC_NS   = 66,
  parameter int     T_RAS_NS  = 44,
  parameter int     T_XSR_NS  = 75,
  parameter int     REFI_NS   = 7810,
  parameter longint WINDOW_NS = 64_000_000,
  parameter int     BURST_LEN = 8192,
  parameter int     PEND_MAX  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_mode,
  input  logic sr_req,
  input  logic grant,
  output logic rf_req,
  output logic busy,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic a10
);
  function automatic longint ns2cyc(longint ns);
    longint c;
    c = (ns * CLK_MHZ + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int     RP_CYC   = int'(ns2cyc(T_RP_NS));
  localparam int     RC_CYC   = int'(ns2cyc(T_RC_NS));
  localparam int     RAS_CYC  = int'(ns2cyc(T_RAS_NS));
  localparam int     XSR_CYC  = int'(ns2cyc(T_XSR_NS));
  localparam longint REFI_CYC = ns2cyc(REFI_NS);
  localparam longint WIN_CYC  = ns2cyc(WINDOW_NS);
  localparam int     TW       = $clog2(WIN_CYC + 1);
  localparam int     M1       = (RP_CYC > RC_CYC) ? RP_CYC : RC_CYC;
  localparam int     M2       = (RAS_CYC > XSR_CYC) ? RAS_CYC : XSR_CYC;
  localparam int     TMW      = $clog2(((M1 > M2) ? M1 : M2) + 1);
  localparam int     PW       = $clog2(PEND_MAX + 1);
  localparam int     BW       = $clog2(BURST_LEN + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_WRP, S_REF, S_WRC, S_SRE, S_SRH, S_SRX} st_t;

  st_t           st, nxt;
  logic [TW-1:0]  tick_cnt;
  logic [PW-1:0]  pend;
  logic [BW-1:0]  bleft;
  logic [TMW-1:0] tmr;

  wire           in_sr    = (st == S_SRE) || (st == S_SRH) || (st == S_SRX);
  wire [TW-1:0]  lim      = burst_mode ? TW'(WIN_CYC - 1) : TW'(REFI_CYC - 1);
  wire           tick     = !in_sr && (tick_cnt >= lim);
  wire           tick_d   = tick && !burst_mode;
  wire           tick_b   = tick && burst_mode;
  wire           need_ref = (pend != '0) || (bleft != '0);
  wire           take_b   = (st == S_REF) && (bleft != '0);
  wire           take_p   = (st == S_REF) && (bleft == '0) && (pend != '0);
  wire           tdone    = tmr <= TMW'(1);

  assign rf_req = (st == S_IDLE) && (need_ref || sr_req);
  assign busy   = (st != S_IDLE);

  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE: if (grant && rf_req) nxt = S_PRE;
      S_PRE:  nxt = S_WRP;
      S_WRP, S_WRC:
        if (tdone) nxt = need_ref ? S_REF : (sr_req ? S_SRE : S_IDLE);
      S_REF:  nxt = S_WRC;
      S_SRE:  nxt = S_SRH;
      S_SRH:  if (tdone && !sr_req) nxt = S_SRX;
      S_SRX:  if (tdone) nxt = S_REF;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tick_cnt <= '0;
      pend     <= '0;
      bleft    <= '0;
      tmr      <= '0;
    end else begin
      st       <= nxt;
      tick_cnt <= (in_sr || tick) ? '0 : tick_cnt + 1'b1;

      if (st == S_SRE)                                      pend <= '0;
      else if (tick_d && !take_p && pend != PW'(PEND_MAX))  pend <= pend + 1'b1;
      else if (take_p && !tick_d)                           pend <= pend - 1'b1;

      if (st == S_SRE)  bleft <= '0;
      else if (tick_b)  bleft <= BW'(BURST_LEN);
      else if (take_b)  bleft <= bleft - 1'b1;

      if (st == S_PRE)                         tmr <= TMW'(RP_CYC - 1);
      else if (st == S_REF)                    tmr <= TMW'(RC_CYC - 1);
      else if (st == S_SRE)                    tmr <= TMW'(RAS_CYC - 1);
      else if (st == S_SRH && nxt == S_SRX)    tmr <= TMW'(XSR_CYC);
      else if (tmr != '0)                      tmr <= tmr - 1'b1;
    end
  end

  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    a10 = 1'b0;
    cke = 1'b1;
    case (st)
      S_PRE: begin {cs_n, ras_n, cas_n, we_n} = 4'b0010; a10 = 1'b1; end
      S_REF: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      S_SRE: begin {cs_n, ras_n, cas_n, we_n} = 4'b0001; cke = 1'b0; end
      S_SRH: begin {cs_n, ras_n, cas_n, we_n} = 4'b1111; cke = 1'b0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_refresh_seq_chk.sv
module sdram_refresh_seq_chk #(
  parameter int RP_CYC  = 1,
  parameter int RC_CYC  = 1,
  parameter int RAS_CYC = 1,
  parameter int XSR_CYC = 1
) (
  input logic clk,
  input logic rst_n,
  input logic grant,
  input logic rf_req,
  input logic busy,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic a10
);
  localparam int BIG = 1 << 20;

  wire is_pre = !cs_n && ({ras_n, cas_n, we_n} == 3'b010);
  wire is_rfs = !cs_n && ({ras_n, cas_n, we_n} == 3'b001);

  int since_pre, since_ref, low_run, hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_pre <= 0;
      since_ref <= BIG;
      low_run   <= 0;
      hi_run    <= BIG;
    end else begin
      since_pre <= is_pre ? 1 : ((since_pre != 0 && since_pre < BIG) ? since_pre + 1 : since_pre);
      since_ref <= is_rfs ? 1 : ((since_ref < BIG) ? since_ref + 1 : since_ref);
      low_run   <= cke ? 0 : ((low_run < BIG) ? low_run + 1 : low_run);
      hi_run    <= !cke ? 0 : ((hi_run < BIG) ? hi_run + 1 : hi_run);
    end
  end

  a_r3_pre_all: assert property (@(posedge clk) disable iff (!rst_n) is_pre |-> a10);
  a_r3_rp_before_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    is_rfs |-> (since_pre >= RP_CYC));
  a_r4_rc_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    is_rfs |-> (since_ref >= RC_CYC));
  a_r7_sr_owns_bus: assert property (@(posedge clk) disable iff (!rst_n) !cke |-> busy);
  a_r8_residency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (low_run >= RAS_CYC));
  a_r9_exit_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rfs && cke) |-> (hi_run >= XSR_CYC));
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!rf_req && !busy) |=> !busy);
  a_r11_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !$past(cke)) |-> cs_n);
  a_r12_req_idle: assert property (@(posedge clk) disable iff (!rst_n) rf_req |-> !busy);
endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk #(
  .RP_CYC(RP_CYC), .RC_CYC(RC_CYC), .RAS_CYC(RAS_CYC), .XSR_CYC(XSR_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .rf_req(rf_req), .busy(busy),
  .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10)
);

// File: tb/sdram_refresh_seq_tb.sv
module sdram_refresh_seq_tb;
  localparam int RP = 3, RC = 12, RAS = 8, XSR = 14, REFI = 200, WIN = 4000, BL = 4;
  localparam int K_PRE = 1, K_REF = 2, K_SRE = 3, K_BAD = 4;

  logic clk = 1'b0, rst_n = 1'b0, burst_mode = 1'b0, sr_req = 1'b0, grant = 1'b0;
  logic rf_req, busy, cke, cs_n, ras_n, cas_n, we_n, a10;

  always #2.5 clk = ~clk;

  sdram_refresh_seq #(
    .CLK_MHZ(200), .T_RP_NS(15), .T_RC_NS(60), .T_RAS_NS(40), .T_XSR_NS(70),
    .REFI_NS(1000), .WINDOW_NS(20000), .BURST_LEN(BL), .PEND_MAX(8)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .sr_req(sr_req), .grant(grant),
    .rf_req(rf_req), .busy(busy), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(a10)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  int last_cmd = 0, last_ref = 0, rise_cyc = 0, fall_cyc = 0, low_len = 0;
  int exp_kind[$], exp_gap[$];
  string exp_tag[$];
  logic prev_cke = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input int k, input int g, input string tag);
    exp_kind.push_back(k); exp_gap.push_back(g); exp_tag.push_back(tag);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (cke && !prev_cke) begin rise_cyc = cyc; low_len = cyc - fall_cyc; end
    if (!cke && prev_cke) fall_cyc = cyc;
    prev_cke = cke;
    if (!cs_n && {ras_n, cas_n, we_n} != 3'b111) begin
      int k;
      if ({ras_n, cas_n, we_n} == 3'b010 && a10) k = K_PRE;
      else if ({ras_n, cas_n, we_n} == 3'b001 && cke) k = K_REF;
      else if ({ras_n, cas_n, we_n} == 3'b001 && !cke) k = K_SRE;
      else k = K_BAD;
      if (exp_kind.size() == 0) chk(1'b0, "R10 unexpected command", k, 0);
      else begin
        int ek, eg;
        string et;
        ek = exp_kind.pop_front(); eg = exp_gap.pop_front(); et = exp_tag.pop_front();
        chk(k == ek, {et, " command kind"}, k, ek);
        if (eg != 0) chk(cyc - last_cmd == eg, {et, " command spacing"}, cyc - last_cmd, eg);
      end
      last_cmd = cyc;
      if (k == K_REF) last_ref = cyc;
    end
  end

  task automatic pulse_grant();
    grant = 1'b1; @(negedge clk); grant = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_req(input int lim, output int t);
    int n = 0;
    while (!rf_req && n < lim) begin @(negedge clk); n++; end
    t = cyc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", nchk + 1, nfail);
    $finish;
  end

  initial begin
    int t_req, t0;
    bit ok;
    repeat (3) @(negedge clk);
    chk(!busy && !rf_req && cke && {cs_n, ras_n, cas_n, we_n, a10} == 5'b01110, "R1 in reset",
        {busy, rf_req, cke}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rf_req && cke && {cs_n, ras_n, cas_n, we_n, a10} == 5'b01110, "R1 after reset",
        {busy, rf_req, cke}, 3'b001);

    grant = 1'b1; ok = 1'b1;
    repeat (20) begin @(negedge clk); if (busy) ok = 1'b0; end
    grant = 1'b0;
    chk(ok, "R10 grant without request", ok, 1);

    wait_req(400, t_req);
    chk(t_req >= REFI - 2 && t_req <= REFI + 3, "R2 first interval", t_req, REFI);
    push(K_PRE, 0, "R3"); push(K_REF, RP, "R3");
    grant = 1'b1; @(negedge clk); grant = 1'b0;
    chk(busy && !rf_req, "R12 busy while sequencing", {busy, rf_req}, 2'b10);
    wait_idle();
    chk(cyc - last_ref == RC, "R4 release after refresh", cyc - last_ref, RC);

    while (cyc < t_req + 10 * REFI + 20) @(negedge clk);
    chk(rf_req, "R5 debt pending", rf_req, 1);
    push(K_PRE, 0, "R5"); push(K_REF, RP, "R5");
    for (int i = 0; i < 7; i++) push(K_REF, RC, "R5");
    pulse_grant();
    wait_idle();
    chk(exp_kind.size() == 0, "R5 drained count", exp_kind.size(), 0);
    chk(cyc - last_ref == RC, "R4 release after drain", cyc - last_ref, RC);

    sr_req = 1'b1;
    @(negedge clk);
    push(K_PRE, 0, "R7"); push(K_SRE, RP, "R7");
    pulse_grant();
    repeat (60) @(negedge clk);
    chk(!cke && busy, "R7 held in self-refresh", {cke, busy}, 2'b01);
    chk(cs_n, "R11 deselected", cs_n, 1);
    push(K_REF, 0, "R9");
    sr_req = 1'b0;
    wait_idle();
    chk(last_ref - rise_cyc == XSR, "R9 exit wait", last_ref - rise_cyc, XSR);
    chk(cyc - last_ref == RC, "R9 release after exit refresh", cyc - last_ref, RC);
    chk(low_len >= RAS, "R8 long residency", low_len, RAS);

    sr_req = 1'b1;
    @(negedge clk);
    push(K_PRE, 0, "R7"); push(K_SRE, RP, "R7");
    pulse_grant();
    t0 = 0;
    while (cke && t0 < 50) begin @(negedge clk); t0++; end
    sr_req = 1'b0;
    push(K_REF, 0, "R9");
    wait_idle();
    chk(low_len == RAS, "R8 minimum residency", low_len, RAS);
    chk(last_ref - rise_cyc == XSR, "R9 exit wait short", last_ref - rise_cyc, XSR);

    burst_mode = 1'b1;
    t0 = cyc;
    @(negedge clk);
    wait_req(4500, t_req);
    chk(t_req - t0 >= WIN - 300 && t_req - t0 <= WIN + 1, "R6 window", t_req - t0, WIN);
    push(K_PRE, 0, "R6"); push(K_REF, RP, "R6");
    for (int i = 0; i < BL - 1; i++) push(K_REF, RC, "R6");
    pulse_grant();
    wait_idle();
    chk(exp_kind.size() == 0, "R6 batch count", exp_kind.size(), 0);
    repeat (100) @(negedge clk);
    chk(!rf_req && !busy, "R6 no leftover debt", rf_req, 0);

    chk(exp_kind.size() == 0, "R3 scoreboard empty", exp_kind.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule